// File: doc/BRIEF.md
# Interrupt Redirection Table with Indirect Register Access

This block sits between a set of external interrupt lines and a processor-side interrupt controller. Each line has one 64-bit table entry. The entry holds the vector number to deliver, a mask flag and a destination ID. When an unmasked line rises, the block emits a single message that carries that entry's vector, its destination and the line's index. The message leaves through a valid/ready handshake.

Software cannot see the table directly. It first writes an offset into a select register and then reads or writes a 32-bit data window. An entry spans two offsets. A write to the lower offset is held in a staging register, and the entry changes only when its upper offset is written. At that moment both halves commit together.

Top module: `irt_router`

## Requirements
- R1: A write to port address 0x00 loads the select register from bits 7:0 of the write data. A read of address 0x00 returns the select value zero-extended to 32 bits.
- R2: Entry n sits at select offsets 0x10+2n (bits 31:0) and 0x11+2n (bits 63:32). A read of the window at address 0x10 returns the committed half, and all 64 bits read back as written.
- R3: A write to the lower offset of an entry does not change that entry's read-back value or its routing. The following write to the upper offset commits the staged lower half and the new upper half together.
- R4: After reset the select register is 0 and every entry reads 0x00010000 in its lower half and 0 in its upper half, so every entry is masked. No message is valid.
- R5: A rising edge on an unmasked line produces a message. The message carries vector = entry bits 7:0, destination = entry bits 63:56 and source = the line index. It becomes valid on the second clock edge after the first edge that samples the line high. A vector may differ from the line number.
- R6: An entry whose bit 16 is 1 is masked, and a rising edge on its line produces no message.
- R7: When several lines are pending, messages leave in ascending line-index order.
- R8: While the message is valid and not accepted, valid and all message fields hold steady. Valid drops after acceptance when nothing else is pending.
- R9: A line held high produces only one message until it falls and rises again.
- R10: When the select value is outside the entry range, window writes change no entry and window reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address: 0x00 select, 0x10 window |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| irq_in | input | NUM_IN | Edge-triggered interrupt lines, synchronous to clk |
| msg_valid | output | 1 | Interrupt message valid |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Vector of the message |
| msg_dest | output | 8 | Destination ID of the message |
| msg_src | output | clog2(NUM_IN) | Index of the line that raised the message |

## Verification
The bench builds the block with its default of 24 lines and a 5-bit register address. This places the last entry at offsets 0x3E/0x3F and makes a 5-bit source index the widest value the arbiter returns. With these values the bench can reach the first and the last entry and select offsets just past the table. It can also test priority between non-adjacent lines whose vectors have nothing to do with their line numbers.

// File: rtl/irt_pkg.sv
package irt_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned VEC_W    = 8;
   localparam int unsigned DEST_W   = 8;
   localparam int unsigned MASK_POS = 16;
   localparam logic [WORD_W-1:0] LO_RESET = 32'h0001_0000;

   typedef logic [WORD_W-1:0] word_t;

   typedef struct packed {
      word_t hi;
      word_t lo;
   } entry_t;
endpackage

// File: rtl/irt_regwin.sv
module irt_regwin
   import irt_pkg::*;
#(
   parameter int NUM_IN     = 24,
   parameter int ADDR_W     = 5,
   parameter int SEL_ADDR   = 0,
   parameter int WIN_ADDR   = 16,
   parameter int ENTRY_BASE = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [ADDR_W-1:0]        cfg_addr,
   input  word_t                    cfg_wdata,
   output word_t                    cfg_rdata,
   output logic [NUM_IN-1:0][VEC_W-1:0]  ent_vec,
   output logic [NUM_IN-1:0][DEST_W-1:0] ent_dest,
   output logic [NUM_IN-1:0]        ent_mask
);
   localparam int IDX_W = $clog2(NUM_IN);
   localparam logic [ADDR_W-1:0] SEL_A   = ADDR_W'(SEL_ADDR);
   localparam logic [ADDR_W-1:0] WIN_A   = ADDR_W'(WIN_ADDR);
   localparam logic [8:0]        OFF_LO  = 9'(ENTRY_BASE);
   localparam logic [8:0]        OFF_END = 9'(ENTRY_BASE + 2*NUM_IN);

   initial begin
      assert (ENTRY_BASE % 2 == 0) else $error("ENTRY_BASE must be even");
      assert (ENTRY_BASE + 2*NUM_IN <= 256) else $error("table exceeds select range");
      assert (SEL_ADDR != WIN_ADDR) else $error("select and window collide");
      assert (WIN_ADDR < (1 << ADDR_W)) else $error("ADDR_W too narrow");
   end

   logic [7:0]       sel_q;
   entry_t           tbl_q [NUM_IN];
   word_t            stg_q [NUM_IN];

   logic [8:0]       sel_ext, rel;
   logic             in_range, half_hi;
   logic [IDX_W-1:0] widx;
   logic             win_wr, wr_lo, wr_hi;

   assign sel_ext  = {1'b0, sel_q};
   assign rel      = sel_ext - OFF_LO;
   assign in_range = (sel_ext >= OFF_LO) && (sel_ext < OFF_END);
   assign half_hi  = rel[0];
   assign widx     = rel[IDX_W:1];
   assign win_wr   = cfg_we && (cfg_addr == WIN_A) && in_range;
   assign wr_lo    = win_wr && !half_hi;
   assign wr_hi    = win_wr && half_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (cfg_we && (cfg_addr == SEL_A)) begin
         sel_q <= cfg_wdata[7:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_IN; i++) begin
            stg_q[i] <= LO_RESET;
            tbl_q[i] <= '{hi: '0, lo: LO_RESET};
         end
      end else begin
         if (wr_lo) stg_q[widx] <= cfg_wdata;
         if (wr_hi) tbl_q[widx] <= '{hi: cfg_wdata, lo: stg_q[widx]};
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (cfg_addr == SEL_A) begin
         cfg_rdata = {24'h0, sel_q};
      end else if (cfg_addr == WIN_A && in_range) begin
         cfg_rdata = half_hi ? tbl_q[widx].hi : tbl_q[widx].lo;
      end
   end

   for (genvar g = 0; g < NUM_IN; g++) begin : g_ent
      assign ent_vec[g]  = tbl_q[g].lo[VEC_W-1:0];
      assign ent_dest[g] = tbl_q[g].hi[WORD_W-1 -: DEST_W];
      assign ent_mask[g] = tbl_q[g].lo[MASK_POS];

      // R3: a committed entry changes only through an upper-half write to it
      assert_commit_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (tbl_q[g] != $past(tbl_q[g])) |-> ($past(wr_hi) && $past(widx) == IDX_W'(g)));
   end
endmodule

// File: rtl/irt_edge.sv
module irt_edge #(
   parameter int NUM_IN = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] irq_in,
   input  logic [NUM_IN-1:0] mask,
   input  logic [NUM_IN-1:0] clr,
   output logic [NUM_IN-1:0] pend
);
   initial begin
      assert (NUM_IN >= 2) else $error("NUM_IN must be at least 2");
   end

   logic [NUM_IN-1:0] prev_q;

   for (genvar g = 0; g < NUM_IN; g++) begin : g_line
      logic rise;
      assign rise = irq_in[g] && !prev_q[g];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q[g] <= 1'b0;
            pend[g]   <= 1'b0;
         end else begin
            prev_q[g] <= irq_in[g];
            if (rise && !mask[g]) pend[g] <= 1'b1;
            else if (clr[g])      pend[g] <= 1'b0;
         end
      end
   end

   // R6: a flag never becomes pending from a masked or low line
   assert_no_masked_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & ~$past(pend) & ($past(mask) | ~$past(irq_in))) == '0);
endmodule

// File: rtl/irt_prio.sv
module irt_prio #(
   parameter int NUM_IN = 24,
   parameter int IDX_W  = $clog2(NUM_IN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] req,
   output logic [NUM_IN-1:0] grant,
   output logic [IDX_W-1:0]  idx,
   output logic              any
);
   always_comb begin
      grant = '0;
      idx   = '0;
      for (int i = NUM_IN - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant = '0;
            grant[i] = 1'b1;
            idx = IDX_W'(i);
         end
      end
      any = |req;
   end

   // R7: at most one grant, only to a requester, and present whenever any request is
   assert_grant_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~req) == '0) && ((grant != '0) == (req != '0)));
endmodule

// File: rtl/irt_router.sv
module irt_router
   import irt_pkg::*;
#(
   parameter int NUM_IN = 24,
   parameter int ADDR_W = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [ADDR_W-1:0]         cfg_addr,
   input  logic [31:0]               cfg_wdata,
   output logic [31:0]               cfg_rdata,
   input  logic [NUM_IN-1:0]         irq_in,
   output logic                      msg_valid,
   input  logic                      msg_ready,
   output logic [7:0]                msg_vector,
   output logic [7:0]                msg_dest,
   output logic [$clog2(NUM_IN)-1:0] msg_src
);
   localparam int IDX_W = $clog2(NUM_IN);

   logic [NUM_IN-1:0][VEC_W-1:0]  ent_vec;
   logic [NUM_IN-1:0][DEST_W-1:0] ent_dest;
   logic [NUM_IN-1:0]             ent_mask;
   logic [NUM_IN-1:0]             pend, req, grant, clr;
   logic [IDX_W-1:0]              win_idx;
   logic                          win_any, slot_free;

   irt_regwin #(.NUM_IN(NUM_IN), .ADDR_W(ADDR_W)) regwin_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .ent_vec(ent_vec), .ent_dest(ent_dest), .ent_mask(ent_mask)
   );

   irt_edge #(.NUM_IN(NUM_IN)) edge_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask(ent_mask),
      .clr(clr), .pend(pend)
   );

   assign req = pend & ~ent_mask;

   irt_prio #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) prio_i (
      .clk(clk), .rst_n(rst_n), .req(req), .grant(grant),
      .idx(win_idx), .any(win_any)
   );

   assign slot_free = !msg_valid || msg_ready;
   assign clr       = (slot_free && win_any) ? grant : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid  <= 1'b0;
         msg_vector <= '0;
         msg_dest   <= '0;
         msg_src    <= '0;
      end else if (slot_free) begin
         msg_valid <= win_any;
         if (win_any) begin
            msg_vector <= ent_vec[win_idx];
            msg_dest   <= ent_dest[win_idx];
            msg_src    <= win_idx;
         end
      end
   end

   // R8: a stalled message keeps valid and every field
   assert_msg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector)
                                     && $stable(msg_dest) && $stable(msg_src)));
endmodule

// File: tb/irt_router_tb_top.sv
`timescale 1ns/1ps
module irt_router_tb_top;
   localparam int NUM_IN = 24;
   localparam int ADDR_W = 5;
   localparam int IDX_W  = $clog2(NUM_IN);
   localparam logic [4:0] A_SEL = 5'h00;
   localparam logic [4:0] A_WIN = 5'h10;

   localparam int NV = 6;
   localparam int          V_LINE [NV] = '{0, 3, 7, 12, 17, 23};
   localparam logic [7:0]  V_VEC  [NV] = '{8'h41, 8'h20, 8'hFE, 8'h33, 8'h05, 8'h80};
   localparam logic [7:0]  V_DEST [NV] = '{8'h01, 8'h7F, 8'h02, 8'hA5, 8'h3C, 8'hFF};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [ADDR_W-1:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [NUM_IN-1:0] irq_in = '0;
   logic msg_valid, msg_ready = 1'b0;
   logic [7:0] msg_vector, msg_dest;
   logic [IDX_W-1:0] msg_src;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   irt_router #(.NUM_IN(NUM_IN), .ADDR_W(ADDR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_in(irq_in),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
      .msg_dest(msg_dest), .msg_src(msg_src)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic prog(input int n, input logic [31:0] lo, input logic [31:0] hi);
      wr(A_SEL, 32'(8'h10 + 2*n));
      wr(A_WIN, lo);
      wr(A_SEL, 32'(8'h11 + 2*n));
      wr(A_WIN, hi);
   endtask

   task automatic rd_entry(input int n, output logic [31:0] lo, output logic [31:0] hi);
      wr(A_SEL, 32'(8'h10 + 2*n));
      rd(A_WIN, lo);
      wr(A_SEL, 32'(8'h11 + 2*n));
      rd(A_WIN, hi);
   endtask

   // drive lines high for one cycle; returns just after the load edge
   task automatic pulse(input logic [NUM_IN-1:0] lines);
      @(negedge clk); irq_in = lines;
      @(negedge clk); irq_in = '0;
      @(negedge clk);
   endtask

   task automatic accept;
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL R8 watchdog: actual=timeout expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      logic [31:0] lo, hi, d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R4 reset state
      chk("R4 valid after reset", 64'(msg_valid), 64'h0);
      rd(A_SEL, d);
      chk("R4 select after reset", 64'(d), 64'h0);
      rd_entry(0, lo, hi);
      chk("R4 entry0 lo", 64'(lo), 64'h0001_0000);
      chk("R4 entry0 hi", 64'(hi), 64'h0);
      rd_entry(23, lo, hi);
      chk("R4 entry23 lo", 64'(lo), 64'h0001_0000);

      // R1 select register
      wr(A_SEL, 32'hFFFF_FF2A);
      rd(A_SEL, d);
      chk("R1 select readback", 64'(d), 64'h2A);

      // vector table: program, read back, fire, check message
      for (int v = 0; v < NV; v++) begin
         prog(V_LINE[v], 32'hC0A0_0000 | 32'(V_VEC[v]), {V_DEST[v], 24'h00ABCD});
         rd_entry(V_LINE[v], lo, hi);
         chk("R2 readback lo", 64'(lo), 64'(32'hC0A0_0000 | 32'(V_VEC[v])));
         chk("R2 readback hi", 64'(hi), 64'({V_DEST[v], 24'h00ABCD}));
         pulse(NUM_IN'(1) << V_LINE[v]);
         chk("R5 valid", 64'(msg_valid), 64'h1);
         chk("R5 vector", 64'(msg_vector), 64'(V_VEC[v]));
         chk("R5 dest", 64'(msg_dest), 64'(V_DEST[v]));
         chk("R5 src", 64'(msg_src), 64'(V_LINE[v]));
         @(negedge clk);
         chk("R8 held valid", 64'(msg_valid), 64'h1);
         chk("R8 held vector", 64'(msg_vector), 64'(V_VEC[v]));
         accept();
         chk("R8 valid drops", 64'(msg_valid), 64'h0);
      end

      // R3 staging: lower write alone is invisible
      wr(A_SEL, 32'h14);
      wr(A_WIN, 32'h0000_0099);
      rd(A_WIN, d);
      chk("R3 staged lo hidden", 64'(d), 64'h0001_0000);
      pulse(NUM_IN'(1) << 2);
      chk("R3 still masked", 64'(msg_valid), 64'h0);
      wr(A_SEL, 32'h15);
      wr(A_WIN, 32'h1100_0000);
      wr(A_SEL, 32'h14);
      rd(A_WIN, d);
      chk("R3 committed lo", 64'(d), 64'h99);
      pulse(NUM_IN'(1) << 2);
      chk("R3 msg vector", 64'(msg_vector), 64'h99);
      chk("R3 msg dest", 64'(msg_dest), 64'h11);
      accept();

      // R6 masking
      pulse(NUM_IN'(1) << 5);
      chk("R6 reset-masked line", 64'(msg_valid), 64'h0);
      prog(3, 32'h0001_0020, 32'h7F00_0000);
      pulse(NUM_IN'(1) << 3);
      chk("R6 remasked line", 64'(msg_valid), 64'h0);

      // R7 priority
      prog(1, 32'h0000_00B1, 32'h0100_0000);
      prog(4, 32'h0000_00B4, 32'h0400_0000);
      pulse((NUM_IN'(1) << 4) | (NUM_IN'(1) << 1));
      chk("R7 first src", 64'(msg_src), 64'd1);
      chk("R7 first vector", 64'(msg_vector), 64'hB1);
      accept();
      chk("R7 second valid", 64'(msg_valid), 64'h1);
      chk("R7 second src", 64'(msg_src), 64'd4);
      accept();
      chk("R7 drained", 64'(msg_valid), 64'h0);

      // R9 held level
      @(negedge clk); irq_in[0] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R9 first message", 64'(msg_valid), 64'h1);
      accept();
      repeat (3) @(negedge clk);
      chk("R9 no retrigger", 64'(msg_valid), 64'h0);
      irq_in[0] = 1'b0;

      // R10 out-of-range select
      wr(A_SEL, 32'h40);
      wr(A_WIN, 32'hDEAD_BEEF);
      rd(A_WIN, d);
      chk("R10 read zero", 64'(d), 64'h0);
      rd_entry(23, lo, hi);
      chk("R10 entry23 lo kept", 64'(lo), 64'hC0A0_0080);
      chk("R10 entry23 hi kept", 64'(hi), 64'hFF00_ABCD);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule